// File: doc/BRIEF.md
# DAC Holding-to-Output Transfer Controller

This block is the digital front end of one converter channel. Software stores a sample in a holding register through one of three alignment views of a write port: 12-bit right-justified, 12-bit left-justified or 8-bit right-justified. A dual-channel form of each view takes this channel's share of a 32-bit word. The output register that drives the converter core cannot be written. It is loaded only from the holding register, by a transfer that the controller schedules.

When trigger mode is off, a valid write starts the transfer itself. When trigger mode is on, writes only fill the holding register, and an enabled trigger pulse starts the transfer using the holding value present before that edge. A clock-speed mode field lengthens the transfer pipeline and also sets the minimum spacing between output updates. A busy flag covers the window in which a further write or trigger is not allowed. A one-cycle violation flag reports any write or trigger that arrives inside that window. An optional signed-format mode inverts the sample's top bit, which turns two's-complement data into offset binary.

Top module: `dac_hold_xfer`

## Requirements
- R1: While reset is held and in the first cycle after it, `dout` is 0x000 and `dout_upd`, `busy` and `viol` are 0.
- R2: `wr_alias` selects the view. 2'b00 takes halfword bits 11:0. 2'b01 takes halfword bits 15:4. 2'b10 places the byte in bits 11:4 with bits 3:0 zero. 2'b11 is ignored: it changes neither the holding register nor the output, and it does not raise `busy`.
- R3: With `wr_dual` clear, the halfword is `wr_data[15:0]` and the byte is `wr_data[7:0]`. With `wr_dual` set, the halfword is `wr_data[16*CH_SLOT+15 : 16*CH_SLOT]` and the byte is `wr_data[8*CH_SLOT+7 : 8*CH_SLOT]`.
- R4: With `trig_en` clear, a write accepted at clock edge k loads `dout` at edge k+1+E. `dout_upd` is high for exactly the one cycle after that edge.
- R5: With `trig_en` set, a write does not start a transfer. A `trig` pulse accepted at edge k loads `dout` at edge k+3+E with the holding value present before edge k.
- R6: The extra latency E is 0 for `hf_mode` 2'b00, 1 for 2'b01, and 2 for 2'b10. The reserved code 2'b11 behaves as 2'b10.
- R7: After an accepted write or trigger, `busy` is high for exactly L+S-1 cycles, where L is the transfer latency of R4 or R5 and S is 3, 5 or 7 for `hf_mode` 00, 01 or 10/11.
- R8: A valid write, or a trigger while `trig_en` is set, that arrives while `busy` is high raises `viol` for one cycle and starts no transfer. Such a write still loads the holding register.
- R9: With `signed_fmt` set at acceptance, bit 11 of the transferred value is inverted: 0x000 becomes 0x800, 0xFFF becomes 0x7FF, and 0x800 becomes 0x000.
- R10: A `trig` pulse while `trig_en` is clear has no effect.
- R11: `dout` changes only in a cycle where `dout_upd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_alias | input | 2 | Alignment view of the write |
| wr_dual | input | 1 | Dual-channel form of the view |
| wr_data | input | 32 | Write data word |
| trig_en | input | 1 | Transfer waits for a trigger when set |
| trig | input | 1 | Trigger pulse |
| hf_mode | input | 2 | Clock-speed mode: extra latency and update spacing |
| signed_fmt | input | 1 | Invert the MSB on transfer |
| dout | output | 12 | Output register value |
| dout_upd | output | 1 | One-cycle strobe when `dout` is loaded |
| busy | output | 1 | Transfer or spacing window in progress |
| viol | output | 1 | Write or trigger arrived inside the busy window |

## Verification
The bench checks the exact load cycle for every latency combination. In trigger mode it also confirms that a write alone never moves data. A design with an off-by-one pipeline, or one that transferred on the write, would strobe a cycle early or late. The bench measures the busy window length in each mode, including the reserved code, which a wrong spacing table would shorten or stretch. It writes a second sample inside the busy window: `viol` must pulse, `dout` must keep the first sample, and a later trigger must deliver the second sample. A design that restarted the transfer, or dropped the write from the holding register, would fail one of these checks. Reserved-view writes, triggers while trigger mode is off, the three signed-format corner values and upper-slot dual writes each target a plausible decode mistake.

// File: rtl/dac_xfer_pkg.sv
package dac_xfer_pkg;

    parameter int DW     = 12;   // converter sample width
    parameter int HW     = 16;   // halfword width of a view
    parameter int BW     = 8;    // byte width of the 8-bit view
    parameter int WORD_W = 32;   // write port width

    parameter int BASE_WR   = 1; // write-to-load latency, untriggered
    parameter int BASE_TRIG = 3; // trigger-to-load latency
    parameter int MAX_EXTRA = 2;
    parameter int MAX_GAP   = 7;

    localparam int MAX_SPAN = BASE_TRIG + MAX_EXTRA + MAX_GAP - 1;
    localparam int CNT_W    = $clog2(MAX_SPAN + 1);

    typedef enum logic [1:0] {
        VIEW_R12  = 2'b00,
        VIEW_L12  = 2'b01,
        VIEW_R8   = 2'b10,
        VIEW_RSVD = 2'b11
    } view_e;

    typedef enum logic [1:0] {
        HF_LOW  = 2'b00,
        HF_MID  = 2'b01,
        HF_HIGH = 2'b10,
        HF_RSVD = 2'b11
    } hf_e;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] val;
    } sample_t;

    function automatic int unsigned hf_extra(hf_e m);
        case (m)
            HF_LOW:  return 0;
            HF_MID:  return 1;
            default: return MAX_EXTRA;
        endcase
    endfunction

    function automatic int unsigned hf_gap(hf_e m);
        case (m)
            HF_LOW:  return 3;
            HF_MID:  return 5;
            default: return MAX_GAP;
        endcase
    endfunction

    function automatic logic [DW-1:0] apply_fmt(logic [DW-1:0] v, logic sgn);
        return v ^ {sgn, {(DW-1){1'b0}}};
    endfunction

endpackage

// File: rtl/dac_hold_reg.sv
module dac_hold_reg
    import dac_xfer_pkg::*;
#(
    parameter int CH_SLOT = 0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_view_i,
    input  logic              wr_dual_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output sample_t           wr_o,
    output logic [DW-1:0]     hold_o
);

    logic [HW-1:0] half_w;
    logic [BW-1:0] byte_w;
    view_e         view;

    always_comb begin
        view   = view_e'(wr_view_i);
        half_w = wr_dual_i ? wr_data_i[HW*CH_SLOT +: HW] : wr_data_i[HW-1:0];
        byte_w = wr_dual_i ? wr_data_i[BW*CH_SLOT +: BW] : wr_data_i[BW-1:0];
        wr_o.vld = wr_en_i && (view != VIEW_RSVD);
        case (view)
            VIEW_R12: wr_o.val = half_w[DW-1:0];
            VIEW_L12: wr_o.val = half_w[HW-1 -: DW];
            VIEW_R8:  wr_o.val = {byte_w, {(DW-BW){1'b0}}};
            default:  wr_o.val = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            hold_o <= '0;
        else if (wr_o.vld)
            hold_o <= wr_o.val;
    end

    // R2: a reserved-view write leaves the holding register alone
    p_rsvd_view_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && view == VIEW_RSVD) |=> $stable(hold_o));

endmodule

// File: rtl/dac_xfer_timer.sv
module dac_xfer_timer
    import dac_xfer_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       wr_ok_i,
    input  logic       trig_i,
    input  logic       trig_en_i,
    input  logic [1:0] hf_mode_i,
    output logic       accept_o,
    output logic       load_o,
    output logic       busy_o,
    output logic       viol_o
);

    hf_e              mode;
    logic [CNT_W-1:0] lat, span;
    logic [CNT_W-1:0] pend_q, busy_q;
    logic             start_req;

    always_comb begin
        mode      = hf_e'(hf_mode_i);
        lat       = CNT_W'(trig_en_i ? BASE_TRIG : BASE_WR) + CNT_W'(hf_extra(mode));
        span      = lat + CNT_W'(hf_gap(mode)) - CNT_W'(1);
        start_req = trig_en_i ? trig_i : wr_ok_i;
        busy_o    = (busy_q != '0);
        accept_o  = start_req && !busy_o;
        load_o    = (pend_q == CNT_W'(1));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '0;
            busy_q <= '0;
            viol_o <= 1'b0;
        end else begin
            viol_o <= busy_o && (wr_ok_i || (trig_en_i && trig_i));
            if (accept_o) begin
                pend_q <= lat;
                busy_q <= span;
            end else begin
                if (pend_q != '0) pend_q <= pend_q - CNT_W'(1);
                if (busy_q != '0) busy_q <= busy_q - CNT_W'(1);
            end
        end
    end

    // R7: an accepted request always opens a busy window
    p_busy_after_accept_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        accept_o |=> busy_o);
    // R4: the load lands inside the window it opened
    p_load_in_window_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        load_o |-> busy_o);
    // R8: a violation pulse only follows a busy cycle
    p_viol_after_busy_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        viol_o |-> $past(busy_o));
    // R10: idle with trigger mode off and no write stays idle, whatever trig does
    p_trig_ignored_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && !trig_en_i && !wr_ok_i) |=> !busy_o);

endmodule

// File: rtl/dac_out_reg.sv
module dac_out_reg
    import dac_xfer_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          accept_i,
    input  logic          load_i,
    input  logic [DW-1:0] src_i,
    input  logic          signed_i,
    output logic [DW-1:0] dout_o,
    output logic          upd_o
);

    logic [DW-1:0] snap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            snap_q <= '0;
            dout_o <= '0;
            upd_o  <= 1'b0;
        end else begin
            if (accept_i)
                snap_q <= apply_fmt(src_i, signed_i);
            upd_o <= load_i;
            if (load_i)
                dout_o <= snap_q;
        end
    end

    // R11: the output register only moves together with its strobe
    p_dout_quiet_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        !upd_o |-> $stable(dout_o));

endmodule

// File: rtl/dac_hold_xfer.sv
module dac_hold_xfer
    import dac_xfer_pkg::*;
#(
    parameter int CH_SLOT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_alias,
    input  logic              wr_dual,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              trig_en,
    input  logic              trig,
    input  logic [1:0]        hf_mode,
    input  logic              signed_fmt,
    output logic [DW-1:0]     dout,
    output logic              dout_upd,
    output logic              busy,
    output logic              viol
);

    sample_t       wr_s;
    logic [DW-1:0] hold_v;
    logic [DW-1:0] src_v;
    logic          accept, load;

    dac_hold_reg #(.CH_SLOT(CH_SLOT)) u_hold (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .wr_view_i (wr_alias),
        .wr_dual_i (wr_dual),
        .wr_data_i (wr_data),
        .wr_o      (wr_s),
        .hold_o    (hold_v)
    );

    dac_xfer_timer u_timer (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_ok_i   (wr_s.vld),
        .trig_i    (trig),
        .trig_en_i (trig_en),
        .hf_mode_i (hf_mode),
        .accept_o  (accept),
        .load_o    (load),
        .busy_o    (busy),
        .viol_o    (viol)
    );

    // untriggered transfers carry the word being written; triggered ones the stored word
    assign src_v = trig_en ? hold_v : wr_s.val;

    dac_out_reg u_out (
        .clk_i    (clk),
        .rst_i    (rst),
        .accept_i (accept),
        .load_i   (load),
        .src_i    (src_v),
        .signed_i (signed_fmt),
        .dout_o   (dout),
        .upd_o    (dout_upd)
    );

    // R4: spacing of at least three cycles keeps the strobe to single pulses
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        dout_upd |=> !dout_upd);

endmodule

// File: tb/tb_dac_hold_xfer.sv
module tb_dac_hold_xfer;

    localparam int SLOT = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_alias = 2'b00;
    logic        wr_dual = 1'b0;
    logic [31:0] wr_data = '0;
    logic        trig_en = 1'b0;
    logic        trig = 1'b0;
    logic [1:0]  hf_mode = 2'b00;
    logic        signed_fmt = 1'b0;
    logic [11:0] dout;
    logic        dout_upd, busy, viol;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dac_hold_xfer #(.CH_SLOT(SLOT)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_alias(wr_alias),
        .wr_dual(wr_dual), .wr_data(wr_data), .trig_en(trig_en), .trig(trig),
        .hf_mode(hf_mode), .signed_fmt(signed_fmt), .dout(dout),
        .dout_upd(dout_upd), .busy(busy), .viol(viol)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ext_of(input logic [1:0] m);
        return (m == 2'b00) ? 0 : (m == 2'b01) ? 1 : 2;
    endfunction

    function automatic int gap_of(input logic [1:0] m);
        return (m == 2'b00) ? 3 : (m == 2'b01) ? 5 : 7;
    endfunction

    function automatic logic [11:0] exp_val(input logic [1:0] al, input logic du,
                                            input logic [31:0] d, input logic sg);
        logic [15:0] hw;
        logic [7:0]  bt;
        logic [11:0] v;
        hw = du ? d[16*SLOT +: 16] : d[15:0];
        bt = du ? d[8*SLOT +: 8] : d[7:0];
        if (al == 2'b00)      v = hw[11:0];
        else if (al == 2'b01) v = hw[15:4];
        else                  v = {bt, 4'h0};
        if (sg) v[11] = ~v[11];
        return v;
    endfunction

    // Called at the sample point right after the accepting edge.
    task automatic watch(input int lat, input int gap, input logic [11:0] expv, input string tg);
        int bc;
        logic [11:0] prev;
        bc = 0;
        prev = dout;
        for (int idx = 0; idx < 40; idx++) begin
            if (idx > 0) @(negedge clk);
            chk(dout_upd == (idx == lat), tg, dout_upd, (idx == lat));
            if (idx == lat) chk(dout == expv, {tg, " R2 R3 R9 value"}, dout, expv);
            else            chk(dout == prev, "R11", dout, prev);
            prev = dout;
            if (busy) bc++;
            else break;
        end
        chk(bc == lat + gap - 1, "R7 busy length", bc, lat + gap - 1);
        chk(dout == expv, "R11 holds", dout, expv);
    endtask

    task automatic run_xfer(input logic [1:0] al, input logic du, input logic [31:0] d,
                            input logic [1:0] m, input logic sg, input logic te);
        int lat;
        lat = (te ? 3 : 1) + ext_of(m);
        @(negedge clk);
        trig_en = te; hf_mode = m; signed_fmt = sg;
        wr_en = 1'b1; wr_alias = al; wr_dual = du; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (te) begin
            chk(!busy && !dout_upd, "R5 write alone", {busy, dout_upd}, 0);
            @(negedge clk);
            chk(!busy && !dout_upd, "R5 write alone", {busy, dout_upd}, 0);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
        end
        watch(lat, gap_of(m), exp_val(al, du, d, sg), te ? "R5 R6 timing" : "R4 R6 timing");
    endtask

    task automatic run_trig(input logic [1:0] m, input logic [11:0] expv);
        @(negedge clk);
        trig_en = 1'b1; hf_mode = m; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        watch(3 + ext_of(m), gap_of(m), expv, "R5 trigger");
    endtask

    task automatic idle_watch(input int n, input logic [11:0] expv, input string tg);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!busy && !dout_upd && dout == expv, tg, dout, expv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2468));
        repeat (3) @(negedge clk);
        chk(dout == 12'h000 && !dout_upd && !busy && !viol, "R1 in reset", dout, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(dout == 12'h000 && !dout_upd && !busy && !viol, "R1 after reset", dout, 0);

        // R2 views, untriggered
        run_xfer(2'b00, 1'b0, 32'hFFFF_FABC, 2'b00, 1'b0, 1'b0);
        run_xfer(2'b01, 1'b0, 32'h0000_1234, 2'b00, 1'b0, 1'b0);
        run_xfer(2'b10, 1'b0, 32'h0000_F35A, 2'b00, 1'b0, 1'b0);
        // R3 dual views, upper slot
        run_xfer(2'b00, 1'b1, 32'h0DEF_0123, 2'b00, 1'b0, 1'b0);
        run_xfer(2'b01, 1'b1, 32'h9870_0000, 2'b00, 1'b0, 1'b0);
        run_xfer(2'b10, 1'b1, 32'h0000_C37F, 2'b00, 1'b0, 1'b0);
        // R9 signed corners
        run_xfer(2'b00, 1'b0, 32'h0000_0000, 2'b00, 1'b1, 1'b0);
        run_xfer(2'b00, 1'b0, 32'h0000_0FFF, 2'b00, 1'b1, 1'b0);
        run_xfer(2'b00, 1'b0, 32'h0000_0800, 2'b00, 1'b1, 1'b0);
        // R6 all modes, both trigger settings
        for (int m = 0; m < 4; m++) begin
            run_xfer(2'b00, 1'b0, 32'h0000_0100 + m, 2'(m), 1'b0, 1'b0);
            run_xfer(2'b00, 1'b0, 32'h0000_0200 + m, 2'(m), 1'b0, 1'b1);
        end

        // R10 trigger ignored while trigger mode is off
        @(negedge clk);
        trig_en = 1'b0; hf_mode = 2'b00; signed_fmt = 1'b0; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk(!busy, "R10 no start", busy, 0);
        idle_watch(10, 12'h203, "R10 ignored trigger");

        // R2 reserved view ignored, holding keeps 0x321
        run_xfer(2'b00, 1'b0, 32'h0000_0321, 2'b00, 1'b0, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_alias = 2'b11; wr_data = 32'h0000_0777;
        @(negedge clk);
        wr_en = 1'b0;
        chk(!busy, "R2 reserved no start", busy, 0);
        idle_watch(8, 12'h321, "R2 reserved view");
        run_trig(2'b00, 12'h321);

        // R8 write inside busy window
        @(negedge clk);
        trig_en = 1'b0; hf_mode = 2'b00;
        wr_en = 1'b1; wr_alias = 2'b00; wr_data = 32'h0000_0111;
        @(negedge clk);
        wr_data = 32'h0000_0222;
        chk(busy && !viol, "R8 window open", {busy, viol}, 2);
        @(negedge clk);
        wr_en = 1'b0;
        chk(viol == 1'b1, "R8 viol pulse", viol, 1);
        @(negedge clk);
        chk(viol == 1'b0, "R8 viol single", viol, 0);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(dout == 12'h111, "R8 no restart", dout, 12'h111);
        run_trig(2'b00, 12'h222);

        // R8 trigger inside busy window
        @(negedge clk);
        trig_en = 1'b1; hf_mode = 2'b01; trig = 1'b1;
        @(negedge clk);
        chk(busy && !viol, "R8 trig accepted", {busy, viol}, 2);
        @(negedge clk);
        trig = 1'b0;
        chk(viol == 1'b1, "R8 trig viol", viol, 1);
        while (busy) @(negedge clk);
        idle_watch(3, 12'h222, "R8 no extra load");

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [1:0] al;
            al = 2'($urandom_range(0, 2));
            run_xfer(al, 1'($urandom_range(0, 1)), $urandom(),
                     2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule